// File: doc/BRIEF.md
# Line-Multiplying Video Timing Generator

This block produces the horizontal and vertical timing for a low-resolution picture shown on a display that runs at a higher line rate. It advances one position for each pixel-clock enable. Every native scanline is shown a programmable number of times in a row. The active part of each line is a centred picture with a solid border column on each side. Sync widths and porch lengths come from configuration inputs. The picture size and the border width are fixed by parameters.

The outputs are horizontal sync, vertical sync, a data-enable, a border flag, the native line number and the native pixel number within the picture. A one-cycle vertical-blank event marks the first position after the last active line, so that frame-store updates can fall wholly inside blanking. Configuration inputs are captured only when a frame wraps, so a frame is never drawn with mixed settings.

A line is laid out as front porch, sync pulse, back porch, then the active region. The active region is border, picture and border. The picture shows each native pixel for two enables. A frame starts with the active lines, followed by the vertical front porch, sync and back porch. All vertical values count native lines, and each native line lasts `rep_m1 + 1` output lines.

Top module: `scan_timing_gen`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) places the block at frame position zero and captures the configuration inputs. Afterwards de, pillar and vblank_evt are low, both syncs are inactive when the horizontal front porch is nonzero, and line_no and pix_no are 0.
- R2: Counting enables from the line start, hsync is active for positions hfp to hfp+hsw-1. The back porch lasts hbp enables after the pulse, and the active region begins at position hfp+hsw+hbp. The line total is that value plus 2*PILLAR_W+2*PIC_NATIVE.
- R3: In an active line, de is high over the whole active region. pillar is high with de for the first and last PILLAR_W positions. Between the two borders, pix_no counts 0 to PIC_NATIVE-1, and each value is held for two enables. pix_no is 0 everywhere else.
- R4: Each native line is output cfg_rep_m1+1 times. A frame therefore holds V_ACTIVE*(cfg_rep_m1+1)*(2*PILLAR_W+2*PIC_NATIVE) data-enable positions.
- R5: Native lines V_ACTIVE to V_ACTIVE+vfp-1 form the front porch, the next vsw native lines carry vsync, and vbp more native lines follow. During the vsync lines hsync keeps pulsing once per output line. A frame has (V_ACTIVE+vfp+vsw+vbp)*(cfg_rep_m1+1) hsync pulses.
- R6: line_no advances only when the repeat count of a native line is used up. It is 0 on the first active line of every frame, and it either holds, steps by one or returns to 0.
- R7: vblank_evt is high for exactly one clock, in the cycle where the position has just become the first position of native line V_ACTIVE. It fires once per frame, and de is low at that point.
- R8: cfg_hs_pol and cfg_vs_pol set the active level of each sync (1 = active high, 0 = active low).
- R9: Changes on the configuration inputs have no effect until the enable that wraps the frame back to position zero. From that enable on, all of them apply together.
- R10: When pix_en is low at a rising edge, no output changes, and vblank_evt is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one position per high cycle |
| cfg_rep_m1 | input | RW | Native line repeat count minus one |
| cfg_vfp | input | VW | Vertical front porch, native lines |
| cfg_vsw | input | VW | Vertical sync width, native lines |
| cfg_vbp | input | VW | Vertical back porch, native lines |
| cfg_hfp | input | HW | Horizontal front porch, enables |
| cfg_hsw | input | HW | Horizontal sync width, enables |
| cfg_hbp | input | HW | Horizontal back porch, enables |
| cfg_hs_pol | input | 1 | Horizontal sync active level |
| cfg_vs_pol | input | 1 | Vertical sync active level |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable, border included |
| pillar | output | 1 | Border column within the active region |
| vblank_evt | output | 1 | One-cycle pulse at first blank line |
| line_no | output | VW | Native line number within frame |
| pix_no | output | HW | Native pixel number within picture |

## Verification
Every output is registered from the position that the same rising edge produces. The result of an enabled edge is therefore visible right after that edge, and vblank_evt rises together with the step into the first blank line. A configuration change shows first in the outputs after the wrapping enable. The bench drives inputs on the falling edge. At the next falling edge it checks each output against a position counter that it advances only for enables. Idle cycles are checked for unchanged outputs in the same way, and per-frame totals of hsync pulses, data-enable positions and blank events are checked at each wrap, before the bench loads the new configuration.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
    localparam int unsigned HW = 11;
    localparam int unsigned VW = 9;
    localparam int unsigned RW = 2;

    typedef struct packed {
        logic [RW-1:0] rep_m1;
        logic [VW-1:0] vfp;
        logic [VW-1:0] vsw;
        logic [VW-1:0] vbp;
        logic [HW-1:0] hfp;
        logic [HW-1:0] hsw;
        logic [HW-1:0] hbp;
        logic          hs_pol;
        logic          vs_pol;
    } tcfg_t;

    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic          pillar;
        logic          vbl;
        logic [VW-1:0] line;
        logic [HW-1:0] pix;
    } tout_t;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [RW-1:0] rep;
        logic [VW-1:0] v;
        logic          hlast;
        logic          vlast;
        tcfg_t         cfg;
        tout_t         o;
    } tstate_t;
endpackage

// File: rtl/scan_h_decode.sv
module scan_h_decode
    import scan_timing_pkg::*;
#(
    parameter int unsigned PILLAR_W   = 80,
    parameter int unsigned PIC_NATIVE = 320
) (
    input  logic [HW-1:0] hpos,
    input  logic [HW-1:0] hfp,
    input  logic [HW-1:0] hsw,
    input  logic [HW-1:0] hbp,
    output logic          sync_on,
    output logic          act,
    output logic          pillar,
    output logic          last,
    output logic [HW-1:0] pix
);
    localparam logic [HW-1:0] PILL = HW'(PILLAR_W);
    localparam logic [HW-1:0] PIC  = HW'(2 * PIC_NATIVE);

    logic [HW-1:0] sync_end, act_beg, pic_beg, pic_end, tot_m1, off;
    logic          in_pic;

    always_comb begin
        sync_end = hfp + hsw;
        act_beg  = sync_end + hbp;
        pic_beg  = act_beg + PILL;
        pic_end  = pic_beg + PIC;
        tot_m1   = pic_end + PILL - HW'(1);
        off      = hpos - pic_beg;
        sync_on  = (hpos >= hfp) && (hpos < sync_end);
        act      = hpos >= act_beg;
        in_pic   = (hpos >= pic_beg) && (hpos < pic_end);
        pillar   = act && !in_pic;
        last     = hpos == tot_m1;
        pix      = in_pic ? {1'b0, off[HW-1:1]} : '0;
    end
endmodule

// File: rtl/scan_v_decode.sv
module scan_v_decode
    import scan_timing_pkg::*;
#(
    parameter int unsigned V_ACTIVE = 216
) (
    input  logic [VW-1:0] vpos,
    input  logic [VW-1:0] vfp,
    input  logic [VW-1:0] vsw,
    input  logic [VW-1:0] vbp,
    output logic          sync_on,
    output logic          act,
    output logic          first_blank,
    output logic          last
);
    localparam logic [VW-1:0] VA = VW'(V_ACTIVE);

    logic [VW-1:0] sync_beg, sync_end, tot_m1;

    always_comb begin
        sync_beg    = VA + vfp;
        sync_end    = sync_beg + vsw;
        tot_m1      = sync_end + vbp - VW'(1);
        act         = vpos < VA;
        first_blank = vpos == VA;
        sync_on     = (vpos >= sync_beg) && (vpos < sync_end);
        last        = vpos == tot_m1;
    end
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_timing_pkg::*;
#(
    parameter int unsigned PILLAR_W   = 80,
    parameter int unsigned PIC_NATIVE = 320,
    parameter int unsigned V_ACTIVE   = 216
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic [RW-1:0] cfg_rep_m1,
    input  logic [VW-1:0] cfg_vfp,
    input  logic [VW-1:0] cfg_vsw,
    input  logic [VW-1:0] cfg_vbp,
    input  logic [HW-1:0] cfg_hfp,
    input  logic [HW-1:0] cfg_hsw,
    input  logic [HW-1:0] cfg_hbp,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pillar,
    output logic          vblank_evt,
    output logic [VW-1:0] line_no,
    output logic [HW-1:0] pix_no
);
    tstate_t       s_d, s_q;
    tcfg_t         cfg_in, c_n;
    logic [HW-1:0] h_n;
    logic [RW-1:0] r_n;
    logic [VW-1:0] v_n;

    logic          h_sync_on, h_act, h_pillar, h_last;
    logic [HW-1:0] h_pix;
    logic          v_sync_on, v_act, v_first_blank, v_last;

    always_comb begin
        cfg_in.rep_m1 = cfg_rep_m1;
        cfg_in.vfp    = cfg_vfp;
        cfg_in.vsw    = cfg_vsw;
        cfg_in.vbp    = cfg_vbp;
        cfg_in.hfp    = cfg_hfp;
        cfg_in.hsw    = cfg_hsw;
        cfg_in.hbp    = cfg_hbp;
        cfg_in.hs_pol = cfg_hs_pol;
        cfg_in.vs_pol = cfg_vs_pol;
    end

    // Next position: line, repeat and frame counters cascade on wrap.
    always_comb begin
        h_n = s_q.h;
        r_n = s_q.rep;
        v_n = s_q.v;
        c_n = s_q.cfg;
        if (!rst_n) begin
            h_n = '0;
            r_n = '0;
            v_n = '0;
            c_n = cfg_in;
        end else if (pix_en) begin
            if (s_q.hlast) begin
                h_n = '0;
                if (s_q.rep == s_q.cfg.rep_m1) begin
                    r_n = '0;
                    if (s_q.vlast) begin
                        v_n = '0;
                        c_n = cfg_in;
                    end else begin
                        v_n = s_q.v + 1'b1;
                    end
                end else begin
                    r_n = s_q.rep + 1'b1;
                end
            end else begin
                h_n = s_q.h + 1'b1;
            end
        end
    end

    scan_h_decode #(
        .PILLAR_W  (PILLAR_W),
        .PIC_NATIVE(PIC_NATIVE)
    ) i_hdec (
        .hpos   (h_n),
        .hfp    (c_n.hfp),
        .hsw    (c_n.hsw),
        .hbp    (c_n.hbp),
        .sync_on(h_sync_on),
        .act    (h_act),
        .pillar (h_pillar),
        .last   (h_last),
        .pix    (h_pix)
    );

    scan_v_decode #(
        .V_ACTIVE(V_ACTIVE)
    ) i_vdec (
        .vpos       (v_n),
        .vfp        (c_n.vfp),
        .vsw        (c_n.vsw),
        .vbp        (c_n.vbp),
        .sync_on    (v_sync_on),
        .act        (v_act),
        .first_blank(v_first_blank),
        .last       (v_last)
    );

    // Outputs decoded from the next position so they align with it.
    always_comb begin
        s_d          = s_q;
        s_d.h        = h_n;
        s_d.rep      = r_n;
        s_d.v        = v_n;
        s_d.cfg      = c_n;
        s_d.hlast    = h_last;
        s_d.vlast    = v_last;
        s_d.o.hs     = c_n.hs_pol ? h_sync_on : !h_sync_on;
        s_d.o.vs     = c_n.vs_pol ? v_sync_on : !v_sync_on;
        s_d.o.de     = h_act && v_act;
        s_d.o.pillar = h_pillar && v_act;
        s_d.o.pix    = v_act ? h_pix : '0;
        s_d.o.line   = v_n;
        s_d.o.vbl    = rst_n && pix_en && v_first_blank && (h_n == '0) && (r_n == '0);
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign hsync      = s_q.o.hs;
    assign vsync      = s_q.o.vs;
    assign de         = s_q.o.de;
    assign pillar     = s_q.o.pillar;
    assign vblank_evt = s_q.o.vbl;
    assign line_no    = s_q.o.line;
    assign pix_no     = s_q.o.pix;
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk
    import scan_timing_pkg::*;
#(
    parameter int unsigned PIC_NATIVE = 320,
    parameter int unsigned V_ACTIVE   = 216
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          de,
    input logic          pillar,
    input logic          vblank_evt,
    input logic [VW-1:0] line_no,
    input logic [HW-1:0] pix_no
);
    p_pillar_in_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pillar |-> de);

    p_pix_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_no < HW'(PIC_NATIVE));

    p_de_rows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (line_no < VW'(V_ACTIVE)));

    p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_no) |-> ((line_no == $past(line_no) + 1'b1) || (line_no == '0)));

    p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_evt |=> !vblank_evt);

    p_evt_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_evt |-> ((line_no == VW'(V_ACTIVE)) && !de));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pix_en) |=> ($stable(de) && $stable(pillar) && $stable(line_no)
                                && $stable(pix_no) && !vblank_evt));
endmodule

bind scan_timing_gen scan_timing_chk #(
    .PIC_NATIVE(PIC_NATIVE),
    .V_ACTIVE  (V_ACTIVE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .de        (de),
    .pillar    (pillar),
    .vblank_evt(vblank_evt),
    .line_no   (line_no),
    .pix_no    (pix_no)
);

// File: tb/test_scan_timing_gen.sv
module test_scan_timing_gen;
    import scan_timing_pkg::*;

    localparam int PW = 2;
    localparam int PN = 3;
    localparam int VA = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic [RW-1:0] c_rep;
    logic [VW-1:0] c_vfp, c_vsw, c_vbp;
    logic [HW-1:0] c_hfp, c_hsw, c_hbp;
    logic          c_hp, c_vp;
    logic          hsync, vsync, de, pillar, vblank_evt;
    logic [VW-1:0] line_no;
    logic [HW-1:0] pix_no;

    scan_timing_gen #(.PILLAR_W(PW), .PIC_NATIVE(PN), .V_ACTIVE(VA)) i_scan_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .cfg_rep_m1(c_rep), .cfg_vfp(c_vfp), .cfg_vsw(c_vsw), .cfg_vbp(c_vbp),
        .cfg_hfp(c_hfp), .cfg_hsw(c_hsw), .cfg_hbp(c_hbp),
        .cfg_hs_pol(c_hp), .cfg_vs_pol(c_vp),
        .hsync(hsync), .vsync(vsync), .de(de), .pillar(pillar),
        .vblank_evt(vblank_evt), .line_no(line_no), .pix_no(pix_no)
    );

    int checks = 0, fails = 0;
    int m_rep, m_vfp, m_vsw, m_vbp, m_hfp, m_hsw, m_hbp, m_hp, m_vp;
    int k = 0, frames = 0, hs_cnt = 0, de_cnt = 0, evt_cnt = 0;
    bit last_en = 0, hs_prev = 0, pend = 0, ended = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (frame %0d pos %0d)", tag, act, exp, frames, k);
        end
    endtask

    task automatic set_cfg(input int rep, input int hfp, input int hsw, input int hbp,
                           input int vfp, input int vsw, input int vbp, input int hp, input int vp);
        c_rep = RW'(rep); c_hfp = HW'(hfp); c_hsw = HW'(hsw); c_hbp = HW'(hbp);
        c_vfp = VW'(vfp); c_vsw = VW'(vsw); c_vbp = VW'(vbp);
        c_hp = hp[0]; c_vp = vp[0];
        pend = 1;
    endtask

    task automatic load_model();
        m_rep = int'(c_rep); m_hfp = int'(c_hfp); m_hsw = int'(c_hsw); m_hbp = int'(c_hbp);
        m_vfp = int'(c_vfp); m_vsw = int'(c_vsw); m_vbp = int'(c_vbp);
        m_hp = int'(c_hp); m_vp = int'(c_vp);
        pend = 0;
    endtask

    function automatic int htot();
        return m_hfp + m_hsw + m_hbp + 2 * PW + 2 * PN;
    endfunction

    function automatic int vtot();
        return VA + m_vfp + m_vsw + m_vbp;
    endfunction

    task automatic sample(input bit first);
        int hs0, ln, h, nat, e_hs, e_vs, e_de, e_pic, e_pil, e_pix, e_evt;
        string sfx;
        hs0   = m_hfp + m_hsw + m_hbp;
        ln    = k / htot();
        h     = k % htot();
        nat   = ln / (m_rep + 1);
        e_hs  = (h >= m_hfp && h < m_hfp + m_hsw) ? 1 : 0;
        e_vs  = (nat >= VA + m_vfp && nat < VA + m_vfp + m_vsw) ? 1 : 0;
        e_de  = (nat < VA && h >= hs0) ? 1 : 0;
        e_pic = (e_de == 1 && h >= hs0 + PW && h < hs0 + PW + 2 * PN) ? 1 : 0;
        e_pil = (e_de == 1 && e_pic == 0) ? 1 : 0;
        e_pix = (e_pic == 1) ? (h - hs0 - PW) / 2 : 0;
        e_evt = (last_en && k == VA * (m_rep + 1) * htot()) ? 1 : 0;
        sfx = first ? " R1" : "";
        if (!last_en && !first) sfx = {sfx, " R10"};
        if (pend) sfx = {sfx, " R9"};
        chk({"R2/R8 hsync", sfx}, int'(hsync), (m_hp == 1) ? e_hs : 1 - e_hs);
        chk({"R5/R8 vsync", sfx}, int'(vsync), (m_vp == 1) ? e_vs : 1 - e_vs);
        chk({"R3 de", sfx}, int'(de), e_de);
        chk({"R3 pillar", sfx}, int'(pillar), e_pil);
        chk({"R3 pix_no", sfx}, int'(pix_no), e_pix);
        chk({"R6 line_no", sfx}, int'(line_no), nat);
        chk({"R7 vblank_evt", sfx}, int'(vblank_evt), e_evt);
        if (last_en || first) begin
            if (de) de_cnt++;
            if ((int'(hsync) == m_hp) && !hs_prev) hs_cnt++;
            hs_prev = (int'(hsync) == m_hp);
            if (vblank_evt) evt_cnt++;
        end
    endtask

    task automatic step(input bit en);
        pix_en = en;
        @(posedge clk);
        last_en = en;
        if (en) begin
            k++;
            if (k == htot() * vtot() * (m_rep + 1)) begin
                chk("R5 hsync pulses per frame", hs_cnt, vtot() * (m_rep + 1));
                chk("R4 de positions per frame", de_cnt, VA * (m_rep + 1) * (2 * PW + 2 * PN));
                chk("R7 blank events per frame", evt_cnt, 1);
                hs_cnt = 0; de_cnt = 0; evt_cnt = 0; hs_prev = 0;
                k = 0;
                frames++;
                load_model();
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        bit c_done;
        c_done = 0;
        set_cfg(1, 2, 3, 1, 1, 2, 1, 1, 1);
        load_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pix_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        sample(1);
        for (int i = 0; i < 4000 && frames < 4; i++) begin
            step((i % 5) != 4);
            sample(0);
            if (i == 100) set_cfg(3, 1, 4, 2, 2, 1, 2, 0, 0);
            if (frames == 1 && !c_done && k > 200) begin
                set_cfg(0, 3, 2, 2, 1, 1, 1, 1, 0);
                c_done = 1;
            end
        end
        chk("R9 frames completed", frames, 4);
        finish_run();
    end

    initial begin
        #(4 * 20000);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        finish_run();
    end
endmodule